// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block turns the 32 input lines of a general-purpose I/O port into four interrupt requests for a top-level interrupt controller. Its input is the data-in vector after the port's polarity selection. Each line can raise an interrupt in two ways, and each way has its own enable mask:

- **Level path.** The live input value is the cause.
- **Edge path.** A rising transition is latched into a sticky cause register, which holds it until software acknowledges it.

The block merges the two paths per pin. It then ORs eight consecutive pins into one registered request line.

Software reaches three registers through a plain write port and a combinational read port: the edge cause, the edge mask and the level mask. An acknowledge is a write to the cause register in which the bits to clear are 0 and all other bits are 1. Falling-edge or active-low sensing is obtained by inverting the line before it reaches this block. Any change that such an inversion causes is treated like any other transition. There is no data stream through the block, so every pin is a plain control or status signal with no back-pressure.

Top module: `gpirq_aggregator`

## Requirements
- R1: After reset, the edge cause, edge mask, level mask and all four request outputs read as zero.
- R2: A data-in bit that is 0 in one clock cycle and 1 in the next sets its edge cause bit. The set is visible on the read port after that second clock edge. A 1-to-0 transition sets nothing.
- R3: An edge cause bit stays set, whatever data-in does, until a cause write clears it.
- R4: A write with select 0 (edge cause) clears every cause bit written as 0 and leaves every bit written as 1 unchanged. A written 1 never sets a bit.
- R5: When a rising transition on a pin and a clearing write of that same bit meet in one cycle, the bit is set after the edge.
- R6: A write with select 1 loads the edge mask and a write with select 2 loads the level mask. Each reads back on the same select. Select 3 reads as zero, and writes to it change nothing.
- R7: The pending cause of pin i is (data_in[i] AND level_mask[i]) OR (edge_cause[i] AND edge_mask[i]). A cause whose mask bit is 0 raises no request.
- R8: irq_req[g] is the OR of the pending causes of pins 8g to 8g+7. It is registered, so it follows the pending cause one clock later.
- R9: A line that is already 1 when reset is released records no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 32 | Polarity-adjusted line values |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 cause, 1 edge mask, 2 level mask, 3 none |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read source, same encoding as wr_sel |
| rd_data | output | 32 | Selected register value (combinational) |
| irq_req | output | 4 | Registered per-group interrupt requests |

## Verification
The hardest case to reach from the ports is a rising transition that lands on the same clock edge as a software acknowledge of the same bit. The bench pre-loads other pending bits, then drives the new transition and the clearing write together. It expects only the colliding bit to survive.

A second case is a line held high through reset. The bench keeps several lines high across the release and expects no cause.

A sweep walks every one of the 32 pins through its edge path and its level path in turn. For each pin it predicts which single group request must rise.

// File: rtl/gpirq_pkg.sv
`timescale 1ns/1ps
package gpirq_pkg;
  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_EMASK = 2'd1,
    SEL_LMASK = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpirq_edge_capture.sv
`timescale 1ns/1ps
// Rising-transition detector feeding a sticky cause register.
// Write-zero-to-clear; a new transition beats a same-cycle clear.
module gpirq_edge_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_in,
  input  logic             ack_en,
  input  logic [WIDTH-1:0] ack_keep,
  output logic [WIDTH-1:0] cause_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] kept;

  assign rise = data_in & ~prev_q;
  assign kept = ack_en ? (cause_q & ack_keep) : cause_q;

  // prev resets to all ones so lines high at release do not count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      cause_q <= '0;
    end else begin
      prev_q  <= data_in;
      cause_q <= kept | rise;
    end
  end
endmodule

// File: rtl/gpirq_mask_reg.sv
`timescale 1ns/1ps
module gpirq_mask_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= load_val;
  end
endmodule

// File: rtl/gpirq_group_or.sv
`timescale 1ns/1ps
// Registered OR reduction of consecutive pins into group requests.
module gpirq_group_or #(
  parameter int WIDTH      = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NGROUPS   = WIDTH / GROUP_SIZE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   pending,
  output logic [NGROUPS-1:0] req_q
);
  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[g] <= 1'b0;
      else        req_q[g] <= |pending[g*GROUP_SIZE +: GROUP_SIZE];
    end
  end
endmodule

// File: rtl/gpirq_aggregator.sv
`timescale 1ns/1ps
module gpirq_aggregator #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NGROUPS   = NUM_LINES / GROUP_SIZE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] data_in,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic [1:0]           rd_sel,
  output logic [NUM_LINES-1:0] rd_data,
  output logic [NGROUPS-1:0]   irq_req
);
  import gpirq_pkg::*;

  logic [NUM_LINES-1:0] edge_cause;
  logic [NUM_LINES-1:0] edge_mask;
  logic [NUM_LINES-1:0] level_mask;
  logic [NUM_LINES-1:0] pending;
  logic                 ack_en, emask_ld, lmask_ld;

  assign ack_en   = wr_en && (reg_sel_e'(wr_sel) == SEL_CAUSE);
  assign emask_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_EMASK);
  assign lmask_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_LMASK);

  gpirq_edge_capture #(.WIDTH(NUM_LINES)) u_cause (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .ack_en(ack_en), .ack_keep(wr_data), .cause_q(edge_cause)
  );

  gpirq_mask_reg #(.WIDTH(NUM_LINES)) u_emask (
    .clk(clk), .rst_n(rst_n), .load(emask_ld),
    .load_val(wr_data), .mask_q(edge_mask)
  );

  gpirq_mask_reg #(.WIDTH(NUM_LINES)) u_lmask (
    .clk(clk), .rst_n(rst_n), .load(lmask_ld),
    .load_val(wr_data), .mask_q(level_mask)
  );

  assign pending = (data_in & level_mask) | (edge_cause & edge_mask);

  gpirq_group_or #(.WIDTH(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_grp (
    .clk(clk), .rst_n(rst_n), .pending(pending), .req_q(irq_req)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CAUSE: rd_data = edge_cause;
      SEL_EMASK: rd_data = edge_mask;
      SEL_LMASK: rd_data = level_mask;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpirq_aggregator_chk.sv
`timescale 1ns/1ps
module gpirq_aggregator_chk #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NGROUPS   = NUM_LINES / GROUP_SIZE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] data_in,
  input logic                 wr_en,
  input logic [1:0]           wr_sel,
  input logic [NUM_LINES-1:0] wr_data,
  input logic [NUM_LINES-1:0] cause_q,
  input logic [NUM_LINES-1:0] emask_q,
  input logic [NUM_LINES-1:0] lmask_q,
  input logic [NGROUPS-1:0]   irq_req
);
  logic [NUM_LINES-1:0] seen_q;
  logic [NUM_LINES-1:0] new_rise;
  logic [NUM_LINES-1:0] pend_ck;
  logic [NGROUPS-1:0]   grp_ck;
  logic                 cause_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '1;
    else        seen_q <= data_in;
  end

  assign new_rise = data_in & ~seen_q;
  assign cause_wr = wr_en && (wr_sel == 2'd0);
  assign pend_ck  = (data_in & lmask_q) | (cause_q & emask_q);

  always_comb begin
    for (int g = 0; g < NGROUPS; g++) begin
      grp_ck[g] = 1'b0;
      for (int k = 0; k < GROUP_SIZE; k++)
        grp_ck[g] = grp_ck[g] | pend_ck[g*GROUP_SIZE + k];
    end
  end

  // R2 and R5: a rise always leaves its bit set
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_rise) |=> ((cause_q & $past(new_rise)) == $past(new_rise)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ((cause_q & ~($past(wr_data) | $past(new_rise))) == '0));

  p_one_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ((cause_q & $past(wr_data) & ~$past(new_rise)) ==
                  ($past(cause_q) & $past(wr_data) & ~$past(new_rise))));

  p_emask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (emask_q == $past(wr_data)));

  p_lmask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (lmask_q == $past(wr_data)));

  // R7 and R8: request follows merged pending cause by one clock
  p_group_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == $past(grp_ck)));
endmodule

bind gpirq_aggregator gpirq_aggregator_chk #(
  .NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .cause_q(edge_cause),
  .emask_q(edge_mask), .lmask_q(level_mask), .irq_req(irq_req)
);

// File: tb/gpirq_aggregator_bench.sv
`timescale 1ns/1ps
module gpirq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_prev, m_cause, m_em, m_lm;
  logic [3:0]  m_req;

  always #10 clk = ~clk;

  gpirq_aggregator u_gpirq_aggregator (
    .clk(clk), .rst_n(rst_n), .data_in(din), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Advance one clock, updating the reference model from the requirements.
  task automatic tick();
    logic [31:0] rise, n_cause, pend;
    logic [3:0]  n_req;
    rise    = din & ~m_prev;
    n_cause = m_cause;
    if (wr_en && wr_sel == 2'd0) n_cause = n_cause & wr_data;
    n_cause = n_cause | rise;
    pend = (din & m_lm) | (m_cause & m_em);
    for (int g = 0; g < 4; g++) n_req[g] = |pend[g*8 +: 8];
    @(posedge clk);
    #2;
    if (wr_en && wr_sel == 2'd1) m_em = wr_data;
    if (wr_en && wr_sel == 2'd2) m_lm = wr_data;
    m_cause = n_cause;
    m_req   = n_req;
    m_prev  = din;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic model_cmp(input string tag);
    check({tag, " cause"}, rd_data, m_cause);
    check({tag, " irq"}, {28'd0, irq_req}, {28'd0, m_req});
  endtask

  task automatic read_sel(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    rd_sel = sel; #1;
    check(tag, rd_data, exp);
    rd_sel = 2'd0; #1;
  endtask

  initial begin
    din = 32'h0000_00F0;
    repeat (3) @(posedge clk);
    #2;
    // R1: everything reads zero under reset
    read_sel(2'd0, 32'h0, "R1 cause reset");
    read_sel(2'd1, 32'h0, "R1 emask reset");
    read_sel(2'd2, 32'h0, "R1 lmask reset");
    check("R1 irq reset", {28'd0, irq_req}, 32'h0);
    rst_n = 1'b1;
    m_prev = '1; m_cause = '0; m_em = '0; m_lm = '0; m_req = '0;
    tick();
    // R9: lines high at release give no cause
    check("R9 no edge at release", rd_data, 32'h0);
    tick();
    check("R9 still none", rd_data, 32'h0);

    // R6: mask load, readback, dead select
    wr(2'd1, 32'hA5A5_5A5A);
    read_sel(2'd1, 32'hA5A5_5A5A, "R6 emask readback");
    wr(2'd2, 32'h0F0F_F0F0);
    read_sel(2'd2, 32'h0F0F_F0F0, "R6 lmask readback");
    wr(2'd3, 32'hFFFF_FFFF);
    read_sel(2'd3, 32'h0, "R6 select3 reads zero");
    read_sel(2'd1, 32'hA5A5_5A5A, "R6 select3 write ignored emask");
    read_sel(2'd2, 32'h0F0F_F0F0, "R6 select3 write ignored lmask");
    din = '0;
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0);
    tick();
    model_cmp("R1 settle");

    // R4: writing ones never sets
    wr(2'd0, 32'hFFFF_FFFF);
    check("R4 ones do not set", rd_data, 32'h0);

    // Per-pin sweep over edge and level paths
    for (int i = 0; i < 32; i++) begin
      logic [31:0] bit_i;
      logic [3:0]  grp;
      bit_i = 32'h1 << i;
      grp   = 4'h1 << (i / 8);
      wr(2'd1, bit_i);
      din = bit_i;
      tick();
      check("R2 rise sets cause", rd_data, bit_i);
      check("R8 not yet requested", {28'd0, irq_req}, 32'h0);
      tick();
      check("R8 group request", {28'd0, irq_req}, {28'd0, grp});
      din = '0;
      tick();
      check("R3 cause holds after fall", rd_data, bit_i);
      model_cmp("R2 fall no set");
      wr(2'd0, ~bit_i);
      check("R4 cleared by zero", rd_data, 32'h0);
      tick();
      check("R8 request drops", {28'd0, irq_req}, 32'h0);
      wr(2'd1, 32'h0);
      wr(2'd2, bit_i);
      din = bit_i;
      tick();
      tick();
      check("R7 level request", {28'd0, irq_req}, {28'd0, grp});
      din = '0;
      wr(2'd0, 32'h0);
      tick();
      check("R7 level removed", {28'd0, irq_req}, 32'h0);
      model_cmp("R7 sweep end");
      wr(2'd2, 32'h0);
    end

    // R7: masked edge cause raises nothing
    din = 32'h0000_0100;
    tick(); tick(); tick();
    check("R7 masked cause held", rd_data, 32'h0000_0100);
    check("R7 masked no request", {28'd0, irq_req}, 32'h0);
    din = '0;

    // R8: several groups at once through level path
    wr(2'd2, 32'hFFFF_FFFF);
    din = 32'h0101_0000;
    tick(); tick();
    check("R8 multi group", {28'd0, irq_req}, 32'hC);
    din = 32'h0000_0080;
    tick(); tick();
    check("R8 group0 only", {28'd0, irq_req}, 32'h1);
    din = '0;
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0);

    // R5: collision of new rise and clear of the same bit
    din = 32'h0000_0020;
    tick();
    din = 32'h0;
    tick();
    check("R5 setup bit5 pending", rd_data, 32'h0000_0020);
    din = 32'h0000_0008;
    wr(2'd0, 32'h0);
    check("R5 set wins over clear", rd_data, 32'h0000_0008);
    model_cmp("R5 model");

    // R4: partial acknowledge keeps written ones
    din = 32'h0000_0018;
    tick();
    din = 32'h0;
    wr(2'd0, ~32'h0000_0008);
    check("R4 partial ack", rd_data, 32'h0000_0010);
    model_cmp("R4 model");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule